// File: doc/BRIEF.md
# Multichannel Transceiver PHY Control Register Bank

This block is the software-facing control and status register bank for a serial transceiver with several lanes. Software reaches it over a word-addressed read/write bus. Through it, software can start automatic digital resets, hold manual resets, and pick the serial loopback and CDR lock mode of each lane. It can also read back the ready flags of the reset controller and the CDR lock status of each lane.

A writable channel mask decides which lanes any reset action reaches. The automatic reset triggers are one-cycle pulses that clear themselves. The manual resets are levels that stay asserted until software writes them back to zero. The reset sequencer that consumes the pulses sits outside the block; its TX and RX ready flags come in as plain inputs. Reads return their data one clock after the request.

Top module: `phy_ctl_regbank`

## Requirements
- R1: The channel mask at word 0x041 holds one enable bit per lane (bit n is lane n). When a lane's mask bit is 0, all three of its reset outputs stay low. Mask bits at or above the lane count read as 0 and ignore writes.
- R2: Writing word 0x042 with bit 0 set raises `tx_dig_rst` for exactly one cycle on every lane whose mask bit is set. The pulse is visible in the cycle after the write edge.
- R3: Writing word 0x042 with bit 1 set raises `rx_dig_rst` for exactly one cycle on every masked-in lane, with the same timing as R2.
- R4: Reading word 0x042 returns `rc_tx_ready` in bit 0 and `rc_rx_ready` in bit 1, with all other bits 0.
- R5: Word 0x044 holds three manual reset levels: bit 1 for TX digital, bit 2 for RX analog and bit 3 for RX digital. Each level drives the matching output on masked-in lanes and holds until software writes 0 to its bit.
- R6: Bits 0 and 31:4 of word 0x044 keep no state. They read as 0 whatever was written to them.
- R7: Word 0x061 holds one serial loopback enable per lane, driven on `loopback_en` and readable back.
- R8: Word 0x064 holds the per-lane force-lock-to-data enables and word 0x065 the force-lock-to-reference enables. Both are driven on outputs and readable back.
- R9: Words 0x066 and 0x067 return the live `cdr_lock_data` and `cdr_lock_ref` inputs. Writes to these two words change nothing.
- R10: A read is answered one cycle later, with `bus_rvalid` high and the data on `bus_rdata`. Outside that cycle `bus_rdata` is 0. Unmapped words read as 0, and writes to them change no output.
- R11: Each lane's `tx_dig_rst` and `rx_dig_rst` is the OR of the automatic pulse and the manual level, gated by the lane's current mask bit. A change of mask therefore takes effect on outputs already asserted.
- R12: After reset, the mask is all ones on the implemented lanes. Every other stored bit is 0, so all reset, loopback and force outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| rc_tx_ready | input | 1 | TX ready flag from the reset sequencer |
| rc_rx_ready | input | 1 | RX ready flag from the reset sequencer |
| cdr_lock_data | input | NCH | Per-lane locked-to-data status |
| cdr_lock_ref | input | NCH | Per-lane locked-to-reference status |
| tx_dig_rst | output | NCH | Per-lane TX digital reset |
| rx_ana_rst | output | NCH | Per-lane RX analog reset |
| rx_dig_rst | output | NCH | Per-lane RX digital reset |
| loopback_en | output | NCH | Per-lane serial loopback enable |
| force_ltd | output | NCH | Per-lane force lock-to-data |
| force_ltr | output | NCH | Per-lane force lock-to-reference |

## Verification
The bench writes a partial mask before it fires the triggers. A design that ignored the mask would reset every lane, and one that latched the trigger would hold the reset for more than one cycle. The bench writes all ones to the manual word, then waits idle cycles, to catch reserved bits that keep state and manual levels that decay. It changes the mask while a manual reset is held: a design that sampled the mask only at the write would keep the old lanes in reset. Writes to the status words and to unmapped words are followed by reads and port checks, which expose a design that stores the written data.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
   localparam int DATA_W = 32;

   // Word addresses decoded by software; kept fixed.
   localparam logic [7:0] AD_MASK   = 8'h41;
   localparam logic [7:0] AD_AUTO   = 8'h42;
   localparam logic [7:0] AD_MAN    = 8'h44;
   localparam logic [7:0] AD_LPBK   = 8'h61;
   localparam logic [7:0] AD_FLTD   = 8'h64;
   localparam logic [7:0] AD_FLTR   = 8'h65;
   localparam logic [7:0] AD_SLTD   = 8'h66;
   localparam logic [7:0] AD_SLTR   = 8'h67;

   localparam int AUTO_TX_BIT = 0;
   localparam int AUTO_RX_BIT = 1;
   localparam int MAN_TX_BIT  = 1;
   localparam int MAN_RXA_BIT = 2;
   localparam int MAN_RXD_BIT = 3;

   typedef struct packed {
      logic rx_dig;
      logic rx_ana;
      logic tx_dig;
   } man_rst_t;
endpackage

// File: rtl/phy_ctl_lane.sv
module phy_ctl_lane
   import phy_ctl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     lane_en,
   input  logic     auto_tx,
   input  logic     auto_rx,
   input  man_rst_t man,
   output logic     tx_dig_rst,
   output logic     rx_ana_rst,
   output logic     rx_dig_rst
);
   always_comb begin
      tx_dig_rst = lane_en & (auto_tx | man.tx_dig);
      rx_ana_rst = lane_en & man.rx_ana;
      rx_dig_rst = lane_en & (auto_rx | man.rx_dig);
   end

   assert_masked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en |-> !(tx_dig_rst | rx_ana_rst | rx_dig_rst));

   assert_pulse_or_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en && (auto_rx || man.rx_dig)) |-> rx_dig_rst);
endmodule

// File: rtl/phy_ctl_rdmux.sv
module phy_ctl_rdmux
   import phy_ctl_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NCH-1:0]    mask,
   input  man_rst_t          man,
   input  logic [NCH-1:0]    lpbk,
   input  logic [NCH-1:0]    fltd,
   input  logic [NCH-1:0]    fltr,
   input  logic [NCH-1:0]    sltd,
   input  logic [NCH-1:0]    sltr,
   input  logic              tx_rdy,
   input  logic              rx_rdy,
   output logic [DATA_W-1:0] rvalue
);
   localparam int PAD_W = DATA_W - NCH;

   logic [DATA_W-1:0] x_mask, x_lpbk, x_fltd, x_fltr, x_sltd, x_sltr;

   generate
      if (PAD_W == 0) begin : g_full
         assign x_mask = mask;
         assign x_lpbk = lpbk;
         assign x_fltd = fltd;
         assign x_fltr = fltr;
         assign x_sltd = sltd;
         assign x_sltr = sltr;
      end else begin : g_pad
         localparam logic [PAD_W-1:0] ZP = '0;
         assign x_mask = {ZP, mask};
         assign x_lpbk = {ZP, lpbk};
         assign x_fltd = {ZP, fltd};
         assign x_fltr = {ZP, fltr};
         assign x_sltd = {ZP, sltd};
         assign x_sltr = {ZP, sltr};
      end
   endgenerate

   always_comb begin
      rvalue = '0;
      unique case (addr)
         ADDR_W'(AD_MASK): rvalue = x_mask;
         ADDR_W'(AD_AUTO): begin
            rvalue[AUTO_TX_BIT] = tx_rdy;
            rvalue[AUTO_RX_BIT] = rx_rdy;
         end
         ADDR_W'(AD_MAN): begin
            rvalue[MAN_TX_BIT]  = man.tx_dig;
            rvalue[MAN_RXA_BIT] = man.rx_ana;
            rvalue[MAN_RXD_BIT] = man.rx_dig;
         end
         ADDR_W'(AD_LPBK): rvalue = x_lpbk;
         ADDR_W'(AD_FLTD): rvalue = x_fltd;
         ADDR_W'(AD_FLTR): rvalue = x_fltr;
         ADDR_W'(AD_SLTD): rvalue = x_sltd;
         ADDR_W'(AD_SLTR): rvalue = x_sltr;
         default:          rvalue = '0;
      endcase
   end
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
   import phy_ctl_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   input  logic              rc_tx_ready,
   input  logic              rc_rx_ready,
   input  logic [NCH-1:0]    cdr_lock_data,
   input  logic [NCH-1:0]    cdr_lock_ref,
   output logic [NCH-1:0]    tx_dig_rst,
   output logic [NCH-1:0]    rx_ana_rst,
   output logic [NCH-1:0]    rx_dig_rst,
   output logic [NCH-1:0]    loopback_en,
   output logic [NCH-1:0]    force_ltd,
   output logic [NCH-1:0]    force_ltr
);
   generate
      if (NCH < 1 || NCH > DATA_W) begin : g_bad_nch
         $error("phy_ctl_regbank: NCH must lie in 1..32");
      end
      if (ADDR_W < 7) begin : g_bad_aw
         $error("phy_ctl_regbank: ADDR_W must be at least 7");
      end
   endgenerate

   logic [NCH-1:0]    mask_q, lpbk_q, fltd_q, fltr_q;
   man_rst_t          man_q;
   logic              trig_tx_q, trig_rx_q;
   logic [DATA_W-1:0] rvalue, rdata_q;
   logic              rvalid_q;
   logic              wr_mask, wr_auto, wr_man, wr_lpbk, wr_fltd, wr_fltr;
   logic              wdata_unused;

   assign wdata_unused = ^bus_wdata;

   always_comb begin
      wr_mask = bus_wr && (bus_addr == ADDR_W'(AD_MASK));
      wr_auto = bus_wr && (bus_addr == ADDR_W'(AD_AUTO));
      wr_man  = bus_wr && (bus_addr == ADDR_W'(AD_MAN));
      wr_lpbk = bus_wr && (bus_addr == ADDR_W'(AD_LPBK));
      wr_fltd = bus_wr && (bus_addr == ADDR_W'(AD_FLTD));
      wr_fltr = bus_wr && (bus_addr == ADDR_W'(AD_FLTR));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q    <= '1;
         lpbk_q    <= '0;
         fltd_q    <= '0;
         fltr_q    <= '0;
         man_q     <= '0;
         trig_tx_q <= 1'b0;
         trig_rx_q <= 1'b0;
      end else begin
         trig_tx_q <= wr_auto && bus_wdata[AUTO_TX_BIT];
         trig_rx_q <= wr_auto && bus_wdata[AUTO_RX_BIT];
         if (wr_mask) mask_q <= bus_wdata[NCH-1:0];
         if (wr_lpbk) lpbk_q <= bus_wdata[NCH-1:0];
         if (wr_fltd) fltd_q <= bus_wdata[NCH-1:0];
         if (wr_fltr) fltr_q <= bus_wdata[NCH-1:0];
         if (wr_man) begin
            man_q.tx_dig <= bus_wdata[MAN_TX_BIT];
            man_q.rx_ana <= bus_wdata[MAN_RXA_BIT];
            man_q.rx_dig <= bus_wdata[MAN_RXD_BIT];
         end
      end
   end

   phy_ctl_rdmux #(.NCH(NCH), .ADDR_W(ADDR_W)) u_rdmux (
      .addr   (bus_addr),
      .mask   (mask_q),
      .man    (man_q),
      .lpbk   (lpbk_q),
      .fltd   (fltd_q),
      .fltr   (fltr_q),
      .sltd   (cdr_lock_data),
      .sltr   (cdr_lock_ref),
      .tx_rdy (rc_tx_ready),
      .rx_rdy (rc_rx_ready),
      .rvalue (rvalue)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= bus_rd;
         rdata_q  <= bus_rd ? rvalue : '0;
      end
   end

   assign bus_rdata   = rdata_q;
   assign bus_rvalid  = rvalid_q;
   assign loopback_en = lpbk_q;
   assign force_ltd   = fltd_q;
   assign force_ltr   = fltr_q;

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_lane
         phy_ctl_lane u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .lane_en    (mask_q[n]),
            .auto_tx    (trig_tx_q),
            .auto_rx    (trig_rx_q),
            .man        (man_q),
            .tx_dig_rst (tx_dig_rst[n]),
            .rx_ana_rst (rx_ana_rst[n]),
            .rx_dig_rst (rx_dig_rst[n])
         );
      end
   endgenerate

   assert_tx_trig_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_tx_q |-> $past(bus_wr && bus_addr == ADDR_W'(AD_AUTO) && bus_wdata[AUTO_TX_BIT]));

   assert_rx_trig_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trig_rx_q |-> $past(bus_wr && bus_addr == ADDR_W'(AD_AUTO) && bus_wdata[AUTO_RX_BIT]));

   assert_manual_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(AD_MAN)) |=> $stable(man_q));

   assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);

   assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rvalid |-> (bus_rdata == '0));
endmodule

// File: tb/phy_ctl_regbank_test.sv
module phy_ctl_regbank_test;
   localparam int NCH = 4;
   localparam int AW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_rdata;
   logic          bus_rvalid;
   logic          rc_tx_ready = 1'b1;
   logic          rc_rx_ready = 1'b0;
   logic [NCH-1:0] cdr_lock_data = 4'h9;
   logic [NCH-1:0] cdr_lock_ref  = 4'h6;
   logic [NCH-1:0] tx_dig_rst, rx_ana_rst, rx_dig_rst, loopback_en, force_ltd, force_ltr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   phy_ctl_regbank #(.NCH(NCH), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .rc_tx_ready(rc_tx_ready), .rc_rx_ready(rc_rx_ready),
      .cdr_lock_data(cdr_lock_data), .cdr_lock_ref(cdr_lock_ref),
      .tx_dig_rst(tx_dig_rst), .rx_ana_rst(rx_ana_rst), .rx_dig_rst(rx_dig_rst),
      .loopback_en(loopback_en), .force_ltd(force_ltd), .force_ltr(force_ltr));

   typedef struct packed {
      logic        is_rd;
      logic [7:0]  addr;
      logic [31:0] data;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h41, 32'h0000_000F},  // R12 mask resets to ones
      '{1'b1, 8'h44, 32'h0000_0000},  // R12 manual word clear
      '{1'b1, 8'h61, 32'h0000_0000},  // R12 loopback clear
      '{1'b0, 8'h61, 32'h0000_0005},  // R7
      '{1'b1, 8'h61, 32'h0000_0005},  // R7
      '{1'b0, 8'h64, 32'h0000_000A},  // R8
      '{1'b1, 8'h64, 32'h0000_000A},  // R8
      '{1'b0, 8'h65, 32'h0000_0003},  // R8
      '{1'b1, 8'h65, 32'h0000_0003},  // R8
      '{1'b0, 8'h41, 32'hFFFF_FFF6},  // R1 upper bits dropped
      '{1'b1, 8'h41, 32'h0000_0006},  // R1
      '{1'b0, 8'h44, 32'hFFFF_FFFF},  // R6 reserved bits written
      '{1'b1, 8'h44, 32'h0000_000E},  // R6 only bits 1..3 kept
      '{1'b0, 8'h44, 32'h0000_0000},  // R5 cleared by software
      '{1'b1, 8'h44, 32'h0000_0000},  // R5
      '{1'b0, 8'h66, 32'h0000_FFFF},  // R9 write to status ignored
      '{1'b1, 8'h66, 32'h0000_0009},  // R9 lock-to-data input
      '{1'b1, 8'h67, 32'h0000_0006},  // R9 lock-to-ref input
      '{1'b0, 8'h50, 32'hFFFF_FFFF},  // R10 unmapped write
      '{1'b1, 8'h50, 32'h0000_0000},  // R10 unmapped read
      '{1'b1, 8'h42, 32'h0000_0001},  // R4 tx ready only
      '{1'b1, 8'h05, 32'h0000_0000}   // R10 unmapped read
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata; v = bus_rvalid;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual expired expected finish");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic        v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state at the ports
      check("R12", {8'h0, tx_dig_rst, rx_ana_rst, rx_dig_rst, loopback_en, force_ltd, force_ltr}, 32'h0);
      check("R10", {31'h0, bus_rvalid}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].is_rd) begin
            rd(VEC[i].addr, d, v);
            check($sformatf("vector %0d", i), d, VEC[i].data);
         end else begin
            wr(VEC[i].addr, VEC[i].data);
         end
      end

      // R7 R8 outputs track registers; R10 unmapped write changed nothing
      check("R7", {28'h0, loopback_en}, 32'h5);
      check("R8", {24'h0, force_ltd, force_ltr}, 32'hA3);
      check("R10", {20'h0, tx_dig_rst, rx_ana_rst, rx_dig_rst}, 32'h0);

      // R10 latency and valid
      rd(8'h41, d, v);
      check("R10", {31'h0, v}, 32'h1);
      @(negedge clk);
      check("R10", {31'h0, bus_rvalid}, 32'h0);
      check("R10", bus_rdata, 32'h0);

      // R4 both ready flags
      rc_rx_ready = 1'b1;
      rd(8'h42, d, v);
      check("R4", d, 32'h3);

      // R2 masked TX pulse, mask = 0110
      wr(8'h42, 32'h1);
      check("R2", {28'h0, tx_dig_rst}, 32'h6);
      check("R2", {28'h0, rx_dig_rst}, 32'h0);
      @(negedge clk);
      check("R2", {28'h0, tx_dig_rst}, 32'h0);

      // R3 masked RX pulse
      wr(8'h42, 32'h2);
      check("R3", {24'h0, rx_dig_rst, tx_dig_rst}, 32'h60);
      @(negedge clk);
      check("R3", {28'h0, rx_dig_rst}, 32'h0);

      // R5 manual levels hold, gated by mask 0110
      wr(8'h44, 32'h6);
      repeat (5) @(negedge clk);
      check("R5", {20'h0, tx_dig_rst, rx_ana_rst, rx_dig_rst}, 32'h660);

      // R11 mask change acts on asserted levels, OR with pulse
      wr(8'h41, 32'h3);
      check("R11", {20'h0, tx_dig_rst, rx_ana_rst, rx_dig_rst}, 32'h330);
      wr(8'h42, 32'h2);
      check("R11", {28'h0, rx_dig_rst}, 32'h3);
      @(negedge clk);
      check("R11", {28'h0, rx_dig_rst}, 32'h0);

      // R1 masked-out lanes stay quiet
      wr(8'h41, 32'h0);
      check("R1", {20'h0, tx_dig_rst, rx_ana_rst, rx_dig_rst}, 32'h0);
      wr(8'h42, 32'h3);
      check("R1", {24'h0, tx_dig_rst, rx_dig_rst}, 32'h0);

      // R5 clear by writing zero
      wr(8'h41, 32'hF);
      wr(8'h44, 32'h0);
      check("R5", {20'h0, tx_dig_rst, rx_ana_rst, rx_dig_rst}, 32'h0);

      finish_run();
   end
endmodule